// File: doc/BRIEF.md
# Extended Pointer Address Former

This block turns the 16-bit register-pair pointers of a small 8-bit core into wide addresses. The core presents its six pointer bytes, its page-extension bytes, an operation code, a pointer select and an adjust mode. One clock later the block presents four results. The first is the address to issue: a 24-bit data address, a 24-bit program-memory byte address for a table read, or a 22-bit indirect jump target. The other three are the written-back pointer low, high and page bytes, each with its own write enable.

Each kind of access widens the pointer by its own rule. Data accesses through a pointer always place that pointer's page byte on top. Direct accesses use a dedicated page byte above the immediate. Plain table reads and plain indirect jumps zero-extend the pointer. Extended table reads take the Z page byte, and extended jumps take a jump-extension byte. Post-increment and pre-decrement act on the full 24-bit extended value, so a carry or borrow reaches the page byte. A parameter can remove the extension bytes completely. All addresses then become zero-extended and the page output is held at zero.

Top module: `ptr_addr_unit`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, all write enables and addr_o read zero until the first request is registered.
- R2: A request sampled with req_i high at a rising clock edge produces valid_o high, together with its address and write-back values, for exactly the cycle after that edge. The write enables are low whenever valid_o is low.
- R3: op_i=0 (pointer data access) issues {page, hi, lo}. Pointer select 0 is X (regs_i bytes 1:0, byte 1 high) with page_x_i. Select 1 is Y (bytes 3:2) with page_y_i. Select 2 and select 3 are Z (bytes 5:4) with page_z_i. Byte k of regs_i is bits 8k+7:8k.
- R4: op_i=1 (direct access) issues {page_d_i, imm_i}. The adjust mode is ignored and no write enable is raised.
- R5: op_i=2 (plain table read) always uses Z, zero-extended to 24 bits. Auto-adjust wraps within 16 bits and never raises we_pg_o.
- R6: op_i=3 (extended table read) always uses Z with page_z_i above it, whatever the pointer select is.
- R7: adj_i=1 (post-increment) on ops 0, 2 and 3 issues the unmodified address and writes back that value plus one. On ops 0 and 3 the addition covers all 24 bits, so a carry out of the pointer increments the page byte. we_lo_o and we_hi_o are raised, and we_pg_o is also raised for ops 0 and 3.
- R8: adj_i=2 (pre-decrement) on ops 0, 2 and 3 issues the decremented value and writes back the same value. The borrow crosses the 24 bits in the same way as R7, with the same write enables. adj_i=3 behaves as no adjust.
- R9: op_i=4 (plain indirect jump) issues {6'b0, Z}. op_i=5 (extended jump) issues {jmp_ext_i[5:0], Z}. addr_o[23:22] is zero for both, the adjust mode is ignored, and no write enable is raised. Op codes 6 and 7 issue address zero with no writes.
- R10: With EXT_EN=0, every address has zero in bits 23:16 and new_pg_o and we_pg_o stay zero. Pointer adjust then wraps within 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_i | input | 3 | Access kind (see R3 to R9) |
| ptr_sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2/3 Z |
| adj_i | input | 2 | Adjust: 0 none, 1 post-increment, 2 pre-decrement |
| regs_i | input | 48 | Six pointer bytes, low pair register first |
| imm_i | input | 16 | Direct address for op 1 |
| page_x_i | input | 8 | Page byte for X |
| page_y_i | input | 8 | Page byte for Y |
| page_z_i | input | 8 | Page byte for Z |
| page_d_i | input | 8 | Page byte for direct access |
| jmp_ext_i | input | 8 | Jump extension byte |
| valid_o | output | 1 | Result valid |
| addr_o | output | 24 | Formed address |
| new_lo_o | output | 8 | Written-back pointer low byte |
| new_hi_o | output | 8 | Written-back pointer high byte |
| new_pg_o | output | 8 | Written-back page byte |
| we_lo_o | output | 1 | Write enable, low byte |
| we_hi_o | output | 1 | Write enable, high byte |
| we_pg_o | output | 1 | Write enable, page byte |

## Verification
On every cycle the assertions check the following relations. Write enables appear only with a valid result, and a valid result only follows a request. A page write always comes together with both pointer-byte writes. Jump targets stay within 22 bits. After an extended increment or decrement, the written-back value is the issued address plus one, or equal to it. With extensions removed, the page byte stays at zero. The bench scenarios are needed for everything else: the correct pair and page chosen for each select, Z forced for table reads, the exact carry from 0xFFFF into the page, the borrow from a zero pointer, the 16-bit wrap of plain table reads, and the fact that adjust has no effect on direct and jump operations.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  typedef enum logic [2:0] {
    OP_PTR  = 3'd0,
    OP_DIR  = 3'd1,
    OP_TBL  = 3'd2,
    OP_TBLX = 3'd3,
    OP_JMP  = 3'd4,
    OP_JMPX = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_INC  = 2'd1,
    ADJ_DEC  = 2'd2
  } adj_e;

  localparam int unsigned NUM_PTR = 3;
  localparam logic [1:0]  SEL_Z   = 2'd2;
endpackage

// File: rtl/ptr_pick.sv
module ptr_pick
  import ptr_addr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = 2 * BYTE_W
) (
  input  logic [2*NUM_PTR*BYTE_W-1:0] regs_i,
  input  logic [1:0]                  sel_i,
  input  logic [BYTE_W-1:0]           page_x_i,
  input  logic [BYTE_W-1:0]           page_y_i,
  input  logic [BYTE_W-1:0]           page_z_i,
  output logic [PTR_W-1:0]            ptr_o,
  output logic [BYTE_W-1:0]           page_o,
  output logic [PTR_W-1:0]            z_o
);
  logic [PTR_W-1:0]  pair [NUM_PTR];
  logic [BYTE_W-1:0] page [NUM_PTR];

  // higher-numbered register of each pair is the high byte
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_pair
    assign pair[i] = regs_i[i*PTR_W +: PTR_W];
  end

  assign page[0] = page_x_i;
  assign page[1] = page_y_i;
  assign page[2] = page_z_i;

  logic [1:0] idx;
  assign idx    = (sel_i == 2'd3) ? SEL_Z : sel_i;
  assign ptr_o  = pair[idx];
  assign page_o = page[idx];
  assign z_o    = pair[NUM_PTR-1];
endmodule

// File: rtl/ptr_step.sv
module ptr_step
  import ptr_addr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = 2 * BYTE_W,
  localparam int unsigned EXT_W = 3 * BYTE_W
) (
  input  logic [EXT_W-1:0] val_i,
  input  adj_e             adj_i,
  input  logic             wrap_ptr_i,
  output logic [EXT_W-1:0] nxt_o
);
  logic [EXT_W-1:0] sum;

  always_comb begin
    unique case (adj_i)
      ADJ_INC: sum = val_i + EXT_W'(1);
      ADJ_DEC: sum = val_i - EXT_W'(1);
      default: sum = val_i;
    endcase
    nxt_o = sum;
    // keep carry/borrow inside the pointer when no page is attached
    if (wrap_ptr_i) nxt_o[EXT_W-1:PTR_W] = val_i[EXT_W-1:PTR_W];
  end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter bit          EXT_EN = 1'b1,
  localparam int unsigned PTR_W = 2 * BYTE_W,
  localparam int unsigned EXT_W = 3 * BYTE_W,
  localparam int unsigned JMP_W = EXT_W - 2,
  localparam int unsigned JXT_W = JMP_W - PTR_W,
  localparam int unsigned REG_W = 2 * NUM_PTR * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [1:0]        adj_i,
  input  logic [REG_W-1:0]  regs_i,
  input  logic [PTR_W-1:0]  imm_i,
  input  logic [BYTE_W-1:0] page_x_i,
  input  logic [BYTE_W-1:0] page_y_i,
  input  logic [BYTE_W-1:0] page_z_i,
  input  logic [BYTE_W-1:0] page_d_i,
  input  logic [BYTE_W-1:0] jmp_ext_i,
  output logic              valid_o,
  output logic [EXT_W-1:0]  addr_o,
  output logic [BYTE_W-1:0] new_lo_o,
  output logic [BYTE_W-1:0] new_hi_o,
  output logic [BYTE_W-1:0] new_pg_o,
  output logic              we_lo_o,
  output logic              we_hi_o,
  output logic              we_pg_o
);
  op_e  op;
  adj_e adj;
  logic ptr_op, paged_op;

  assign op       = op_e'(op_i);
  assign ptr_op   = (op == OP_PTR) || (op == OP_TBL) || (op == OP_TBLX);
  assign paged_op = EXT_EN && ((op == OP_PTR) || (op == OP_TBLX));
  assign adj      = (ptr_op && (adj_i == ADJ_INC || adj_i == ADJ_DEC)) ? adj_e'(adj_i) : ADJ_NONE;

  logic [1:0]        sel_eff;
  logic [PTR_W-1:0]  ptr, z_ptr;
  logic [BYTE_W-1:0] page;

  assign sel_eff = (op == OP_TBL || op == OP_TBLX) ? SEL_Z : ptr_sel_i;

  ptr_pick #(.BYTE_W(BYTE_W)) u_pick (
    .regs_i   (regs_i),
    .sel_i    (sel_eff),
    .page_x_i (page_x_i),
    .page_y_i (page_y_i),
    .page_z_i (page_z_i),
    .ptr_o    (ptr),
    .page_o   (page),
    .z_o      (z_ptr)
  );

  logic [EXT_W-1:0] base, nxt;
  assign base = {(paged_op ? page : BYTE_W'(0)), ptr};

  ptr_step #(.BYTE_W(BYTE_W)) u_step (
    .val_i      (base),
    .adj_i      (adj),
    .wrap_ptr_i (!paged_op),
    .nxt_o      (nxt)
  );

  logic [EXT_W-1:0]  addr_d;
  logic [JXT_W-1:0]  jxt;
  logic [BYTE_W-1:0] pg_d;
  logic              we_p_d, we_g_d;

  assign jxt  = (EXT_EN && op == OP_JMPX) ? jmp_ext_i[JXT_W-1:0] : JXT_W'(0);
  assign pg_d = EXT_EN ? page_d_i : BYTE_W'(0);

  always_comb begin
    unique case (op)
      OP_PTR, OP_TBL, OP_TBLX: addr_d = (adj == ADJ_DEC) ? nxt : base;
      OP_DIR:                  addr_d = {pg_d, imm_i};
      OP_JMP, OP_JMPX:         addr_d = EXT_W'({jxt, z_ptr});
      default:                 addr_d = '0;
    endcase
  end

  assign we_p_d = (adj != ADJ_NONE);
  assign we_g_d = we_p_d && paged_op;

  logic              valid_q, we_p_q, we_g_q;
  logic [EXT_W-1:0]  addr_q, wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      we_p_q  <= 1'b0;
      we_g_q  <= 1'b0;
      addr_q  <= '0;
      wb_q    <= '0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        we_p_q <= we_p_d;
        we_g_q <= we_g_d;
        addr_q <= addr_d;
        wb_q   <= nxt;
      end
    end
  end

  assign valid_o  = valid_q;
  assign addr_o   = addr_q;
  assign new_lo_o = wb_q[BYTE_W-1:0];
  assign new_hi_o = wb_q[PTR_W-1:BYTE_W];
  assign new_pg_o = EXT_EN ? wb_q[EXT_W-1:PTR_W] : BYTE_W'(0);
  assign we_lo_o  = valid_q && we_p_q;
  assign we_hi_o  = valid_q && we_p_q;
  assign we_pg_o  = valid_q && we_g_q;
endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter bit          EXT_EN = 1'b1,
  localparam int unsigned EXT_W = 3 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        op_i,
  input logic [1:0]        adj_i,
  input logic              valid_o,
  input logic [EXT_W-1:0]  addr_o,
  input logic [BYTE_W-1:0] new_lo_o,
  input logic [BYTE_W-1:0] new_hi_o,
  input logic [BYTE_W-1:0] new_pg_o,
  input logic              we_lo_o,
  input logic              we_hi_o,
  input logic              we_pg_o
);
  logic paged_req, jump_req;
  assign paged_req = req_i && (op_i == 3'd0 || op_i == 3'd3);
  assign jump_req  = req_i && (op_i == 3'd4 || op_i == 3'd5);

  assert_we_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!we_lo_o && !we_hi_o && !we_pg_o));

  assert_valid_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i));

  assert_pg_with_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_pg_o |-> (we_lo_o && we_hi_o));

  assert_jump_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(jump_req)) |-> (addr_o[EXT_W-1:EXT_W-2] == 2'b00 && !we_lo_o && !we_pg_o));

  assert_plain_tbl_no_pg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(req_i && op_i == 3'd2)) |-> !we_pg_o);

  if (EXT_EN) begin : g_ext
    assert_inc_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(paged_req && adj_i == 2'd1)) |->
        ({new_pg_o, new_hi_o, new_lo_o} == addr_o + EXT_W'(1)));

    assert_dec_borrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(paged_req && adj_i == 2'd2)) |->
        ({new_pg_o, new_hi_o, new_lo_o} == addr_o));
  end else begin : g_noext
    assert_no_page_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (new_pg_o == '0 && !we_pg_o && addr_o[EXT_W-1:EXT_W-BYTE_W] == '0));
  end
endmodule

bind ptr_addr_unit ptr_addr_unit_chk #(.BYTE_W(BYTE_W), .EXT_EN(EXT_EN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .op_i     (op_i),
  .adj_i    (adj_i),
  .valid_o  (valid_o),
  .addr_o   (addr_o),
  .new_lo_o (new_lo_o),
  .new_hi_o (new_hi_o),
  .new_pg_o (new_pg_o),
  .we_lo_o  (we_lo_o),
  .we_hi_o  (we_hi_o),
  .we_pg_o  (we_pg_o)
);

// File: tb/ptr_addr_unit_bench.sv
`timescale 1ns/1ps
module ptr_addr_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [1:0]  adj_i = '0;
  logic [47:0] regs_i = '0;
  logic [15:0] imm_i = '0;
  logic [7:0]  page_x_i = '0, page_y_i = '0, page_z_i = '0, page_d_i = '0, jmp_ext_i = '0;

  logic        valid_o, we_lo_o, we_hi_o, we_pg_o;
  logic [23:0] addr_o;
  logic [7:0]  new_lo_o, new_hi_o, new_pg_o;
  logic        nx_valid, nx_we_lo, nx_we_hi, nx_we_pg;
  logic [23:0] nx_addr;
  logic [7:0]  nx_lo, nx_hi, nx_pg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ptr_addr_unit #(.BYTE_W(8), .EXT_EN(1'b1)) u_ptr_addr_unit (
    .clk_i, .rst_ni, .req_i, .op_i, .ptr_sel_i, .adj_i, .regs_i, .imm_i,
    .page_x_i, .page_y_i, .page_z_i, .page_d_i, .jmp_ext_i,
    .valid_o, .addr_o, .new_lo_o, .new_hi_o, .new_pg_o,
    .we_lo_o, .we_hi_o, .we_pg_o
  );

  ptr_addr_unit #(.BYTE_W(8), .EXT_EN(1'b0)) u_ptr_addr_unit_noext (
    .clk_i, .rst_ni, .req_i, .op_i, .ptr_sel_i, .adj_i, .regs_i, .imm_i,
    .page_x_i, .page_y_i, .page_z_i, .page_d_i, .jmp_ext_i,
    .valid_o(nx_valid), .addr_o(nx_addr), .new_lo_o(nx_lo), .new_hi_o(nx_hi),
    .new_pg_o(nx_pg), .we_lo_o(nx_we_lo), .we_hi_o(nx_we_hi), .we_pg_o(nx_we_pg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ptrs(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    regs_i = {z, y, x};
  endtask

  // drive one request at a falling edge, sample the result one edge later
  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [1:0] adj);
    @(negedge clk_i);
    op_i = op; ptr_sel_i = sel; adj_i = adj; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(valid_o), 32'h0);
    check("R1 addr", 32'(addr_o), 32'h0);
    check("R1 we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after release", 32'(valid_o), 32'h0);
  endtask

  task automatic t_data_ptrs;
    set_ptrs(16'h2211, 16'h4433, 16'h6655);
    page_x_i = 8'hA1; page_y_i = 8'hB2; page_z_i = 8'hC3;
    issue(3'd0, 2'd0, 2'd0);
    check("R3 X", 32'(addr_o), 32'hA12211);
    check("R2 valid", 32'(valid_o), 32'h1);
    check("R2 no we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
    check("R10 X noext", 32'(nx_addr), 32'h002211);
    issue(3'd0, 2'd1, 2'd0);
    check("R3 Y", 32'(addr_o), 32'hB24433);
    issue(3'd0, 2'd2, 2'd0);
    check("R3 Z", 32'(addr_o), 32'hC36655);
    issue(3'd0, 2'd3, 2'd0);
    check("R3 sel3 is Z", 32'(addr_o), 32'hC36655);
    @(negedge clk_i);
    check("R2 single cycle", 32'(valid_o), 32'h0);
  endtask

  task automatic t_direct;
    imm_i = 16'hBEEF; page_d_i = 8'hD4;
    issue(3'd1, 2'd0, 2'd1);
    check("R4 addr", 32'(addr_o), 32'hD4BEEF);
    check("R4 adjust ignored", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
    check("R10 direct noext", 32'(nx_addr), 32'h00BEEF);
  endtask

  task automatic t_table_plain;
    set_ptrs(16'h2211, 16'h4433, 16'hFFFF);
    page_z_i = 8'h07;
    issue(3'd2, 2'd0, 2'd1);
    check("R5 zero-extend", 32'(addr_o), 32'h00FFFF);
    check("R5 wrap", {8'h0, new_pg_o, new_hi_o, new_lo_o} & 32'h0000FFFF, 32'h0);
    check("R5 we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h6);
  endtask

  task automatic t_table_ext;
    set_ptrs(16'h2211, 16'h4433, 16'hFFFF);
    page_z_i = 8'h07; page_x_i = 8'hA1;
    issue(3'd3, 2'd0, 2'd1);
    check("R6 uses Z page", 32'(addr_o), 32'h07FFFF);
    check("R7 carry into page", {8'h0, new_pg_o, new_hi_o, new_lo_o}, 32'h080000);
    check("R7 we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h7);
    check("R10 ext tbl noext addr", 32'(nx_addr), 32'h00FFFF);
    check("R10 noext wrap", {8'h0, nx_pg, nx_hi, nx_lo}, 32'h0);
    check("R10 noext we_pg", 32'(nx_we_pg), 32'h0);
  endtask

  task automatic t_predec;
    set_ptrs(16'h2211, 16'h0000, 16'h6655);
    page_y_i = 8'h05;
    issue(3'd0, 2'd1, 2'd2);
    check("R8 addr", 32'(addr_o), 32'h04FFFF);
    check("R8 writeback", {8'h0, new_pg_o, new_hi_o, new_lo_o}, 32'h04FFFF);
    check("R8 we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h7);
    check("R10 predec noext", 32'(nx_addr), 32'h00FFFF);
    check("R10 predec noext pg", {24'h0, nx_pg}, 32'h0);
    issue(3'd0, 2'd1, 2'd3);
    check("R8 adj3 none", 32'(addr_o), 32'h050000);
    check("R8 adj3 no we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
  endtask

  task automatic t_jumps;
    set_ptrs(16'h2211, 16'h4433, 16'h6655);
    jmp_ext_i = 8'hE5;
    issue(3'd5, 2'd0, 2'd1);
    check("R9 ext jump", 32'(addr_o), 32'h256655);
    check("R9 adjust ignored", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
    check("R10 ext jump noext", 32'(nx_addr), 32'h006655);
    issue(3'd4, 2'd1, 2'd2);
    check("R9 plain jump", 32'(addr_o), 32'h006655);
    issue(3'd7, 2'd0, 2'd1);
    check("R9 reserved op", 32'(addr_o), 32'h0);
    check("R9 reserved no we", {29'h0, we_lo_o, we_hi_o, we_pg_o}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_data_ptrs();
    t_direct();
    t_table_plain();
    t_table_ext();
    t_predec();
    t_jumps();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule